// File: doc/BRIEF.md
# Quad Byte-Lane Video Arithmetic Unit

This block is a packed-SIMD arithmetic unit for pixel work. Each operand word holds four unsigned 8-bit lanes, and one opcode selects the operation. The operations are:

- a byte add that clips at the top of the byte range;
- a half-word add that clips at the top of the 16-bit range;
- an average with rounding, and an average that truncates;
- an absolute-difference step for motion-estimation sums;
- a byte-window select across two words;
- a byte pack.

One operation may be issued each clock. The packed result appears one cycle later, with a valid flag beside it.

The absolute-difference step also adds each lane's difference into its own 16-bit running total. The four totals are always visible on a 64-bit output. They stick at the maximum instead of wrapping, and only a dedicated clear opcode resets them.

The block has no fetch logic and no register file. Whatever sits upstream supplies both operand words, the opcode and the byte offset, and it collects the result word.

Top module: `vqa_top`

## Requirements
- R1: After reset, `res` is zero, `res_valid` is low and all four totals on `sad_acc` are zero.
- R2: An operation presented with `op_valid` high produces its result on `res`, with `res_valid` high, exactly one clock later. In a cycle with `op_valid` low, `res` holds its previous value and `res_valid` goes low on the next clock.
- R3: Opcode 0 adds each byte of `src_lo` to the matching byte of `src_hi`. A sum above 255 yields 255, and there is no wraparound.
- R4: Opcode 1 adds the two 16-bit halves of `src_lo` to the matching halves of `src_hi`. A sum above 65535 yields 65535.
- R5: Opcode 2 gives (a+b+1)>>1 for each byte lane.
- R6: Opcode 3 gives (a+b)>>1 for each byte lane.
- R7: Opcode 4 returns |a-b| for each byte lane, in the same lane position. It also adds that value into the 16-bit total for the lane. Lane i's total sits at `sad_acc[16*i+15:16*i]`.
- R8: A total that would pass 0xFFFF stays at 0xFFFF.
- R9: Opcode 6 sets all four totals to zero and returns a zero result word.
- R10: Opcode 5 returns bits [8*k+31 : 8*k] of the 64-bit value {`src_hi`,`src_lo`}, where k is `align_off`.
- R11: Opcode 7 returns {`src_hi`[23:16], `src_hi`[7:0], `src_lo`[23:16], `src_lo`[7:0]}.
- R12: The totals change only on opcodes 4 and 6 issued with `op_valid` high. Every other opcode, and every idle cycle, leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 3 | Operation select, 0 to 7 |
| src_lo | input | 32 | First operand word; low word for the window select |
| src_hi | input | 32 | Second operand word; high word for the window select |
| align_off | input | 2 | Byte offset for the window select |
| res | output | 32 | Registered packed result |
| res_valid | output | 1 | `res` holds the result of the previous cycle's operation |
| sad_acc | output | 64 | Four 16-bit absolute-difference totals, lane 0 lowest |

## Verification
A wrong lane computation or a wrong result-select path shows on `res` in the cycle right after the faulty operation. The totals are held state, so an update on the wrong opcode or a missed update appears on `sad_acc` one clock after the op that caused it. It then persists until the next clear, so a check of the totals after every operation finds the first bad step. A saturation fault stays hidden until a total reaches its ceiling. For that reason a long run of maximum differences is driven, so the wrap or the stick can be seen at the port.

// File: rtl/vqa_pkg.sv
package vqa_pkg;

    typedef enum logic [2:0] {
        OP_ADD8   = 3'd0,
        OP_ADD16  = 3'd1,
        OP_AVGR   = 3'd2,
        OP_AVGT   = 3'd3,
        OP_SAD    = 3'd4,
        OP_WINDOW = 3'd5,
        OP_SADCLR = 3'd6,
        OP_PACK   = 3'd7
    } vqa_op_e;

endpackage

// File: rtl/vqa_lane.sv
module vqa_lane
    import vqa_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  vqa_op_e      op,
    output logic [W-1:0] lane_out,
    output logic [W-1:0] abs_out
);

    logic [W:0]   sum;
    logic [W-1:0] add_clip;
    logic [W-1:0] avg_rnd;
    logic [W-1:0] avg_trn;

    assign sum      = {1'b0, a} + {1'b0, b};
    assign add_clip = sum[W] ? {W{1'b1}} : sum[W-1:0];
    // halves are added first, so the sum never needs a wider carry
    assign avg_rnd  = (a >> 1) + (b >> 1) + {{(W-1){1'b0}}, a[0] | b[0]};
    assign avg_trn  = (a >> 1) + (b >> 1) + {{(W-1){1'b0}}, a[0] & b[0]};
    assign abs_out  = (a >= b) ? (a - b) : (b - a);

    always_comb begin
        unique case (op)
            OP_ADD8:  lane_out = add_clip;
            OP_AVGR:  lane_out = avg_rnd;
            OP_AVGT:  lane_out = avg_trn;
            OP_SAD:   lane_out = abs_out;
            default:  lane_out = '0;
        endcase
    end

    always_comb begin
        a_r3_clip_not_below: assert (op != OP_ADD8 || (lane_out >= a && lane_out >= b));
        a_r5_avg_between: assert (op != OP_AVGR || (lane_out >= ((a < b) ? a : b) && lane_out <= ((a > b) ? a : b)));
    end

endmodule

// File: rtl/vqa_window.sv
module vqa_window #(
    parameter int LANES = 4,
    parameter int W     = 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [2*LANES*W-1:0] pair,
    input  logic [OFF_W-1:0]     off,
    output logic [LANES*W-1:0]   win
);

    assign win = pair[int'(off)*W +: LANES*W];

endmodule

// File: rtl/vqa_sad_acc.sv
module vqa_sad_acc #(
    parameter int LANES = 4,
    parameter int W     = 8,
    parameter int ACC_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   add_en,
    input  logic                   clr_en,
    input  logic [LANES*W-1:0]     diffs,
    output logic [LANES*ACC_W-1:0] totals
);

    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

    for (genvar i = 0; i < LANES; i++) begin : g_acc
        logic [ACC_W-1:0] acc_q;
        logic [ACC_W:0]   acc_sum;

        assign acc_sum = {1'b0, acc_q} + {{(ACC_W+1-W){1'b0}}, diffs[i*W +: W]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                acc_q <= '0;
            else if (clr_en)
                acc_q <= '0;
            else if (add_en)
                acc_q <= acc_sum[ACC_W] ? ACC_MAX : acc_sum[ACC_W-1:0];
        end

        assign totals[i*ACC_W +: ACC_W] = acc_q;

        // R12: totals keep their value without an enable
        a_r12_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!add_en && !clr_en) |=> $stable(acc_q));
        // R8: a total at its ceiling stays there while accumulating
        a_r8_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (add_en && !clr_en && acc_q == ACC_MAX) |=> (acc_q == ACC_MAX));
        // R7: accumulation never lowers a total
        a_r7_monotone: assert property (@(posedge clk) disable iff (!rst_n)
            (add_en && !clr_en) |=> (acc_q >= $past(acc_q)));
        // R9: clear empties the total
        a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
            clr_en |=> (acc_q == '0));
    end

endmodule

// File: rtl/vqa_top.sv
module vqa_top
    import vqa_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LANE_W = 8,
    parameter int ACC_W = 16,
    localparam int WORD_W = LANES * LANE_W,
    localparam int OFF_W = $clog2(LANES),
    localparam int HALVES = LANES / 2,
    localparam int HALF_W = 2 * LANE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [2:0]             op_code,
    input  logic [WORD_W-1:0]      src_lo,
    input  logic [WORD_W-1:0]      src_hi,
    input  logic [OFF_W-1:0]       align_off,
    output logic [WORD_W-1:0]      res,
    output logic                   res_valid,
    output logic [LANES*ACC_W-1:0] sad_acc
);

    vqa_op_e           op;
    logic [WORD_W-1:0] lane_word;
    logic [WORD_W-1:0] abs_word;
    logic [WORD_W-1:0] half_word;
    logic [WORD_W-1:0] pack_word;
    logic [WORD_W-1:0] win_word;
    logic [WORD_W-1:0] res_d;
    logic [WORD_W-1:0] res_q;
    logic              vld_q;

    assign op = vqa_op_e'(op_code);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vqa_lane #(.W(LANE_W)) u_lane (
            .a        (src_lo[i*LANE_W +: LANE_W]),
            .b        (src_hi[i*LANE_W +: LANE_W]),
            .op       (op),
            .lane_out (lane_word[i*LANE_W +: LANE_W]),
            .abs_out  (abs_word[i*LANE_W +: LANE_W])
        );
    end

    for (genvar k = 0; k < HALVES; k++) begin : g_half
        logic [HALF_W:0] hsum;
        assign hsum = {1'b0, src_lo[k*HALF_W +: HALF_W]} + {1'b0, src_hi[k*HALF_W +: HALF_W]};
        assign half_word[k*HALF_W +: HALF_W] = hsum[HALF_W] ? {HALF_W{1'b1}} : hsum[HALF_W-1:0];
        assign pack_word[k*LANE_W +: LANE_W]          = src_lo[k*HALF_W +: LANE_W];
        assign pack_word[(k+HALVES)*LANE_W +: LANE_W] = src_hi[k*HALF_W +: LANE_W];
    end

    vqa_window #(.LANES(LANES), .W(LANE_W)) u_window (
        .pair (({src_hi, src_lo})),
        .off  (align_off),
        .win  (win_word)
    );

    vqa_sad_acc #(.LANES(LANES), .W(LANE_W), .ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_en (op_valid && op == OP_SAD),
        .clr_en (op_valid && op == OP_SADCLR),
        .diffs  (abs_word),
        .totals (sad_acc)
    );

    always_comb begin
        unique case (op)
            OP_ADD8, OP_AVGR, OP_AVGT, OP_SAD: res_d = lane_word;
            OP_ADD16:  res_d = half_word;
            OP_WINDOW: res_d = win_word;
            OP_PACK:   res_d = pack_word;
            OP_SADCLR: res_d = '0;
            default:   res_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= op_valid;
            if (op_valid)
                res_q <= res_d;
        end
    end

    assign res       = res_q;
    assign res_valid = vld_q;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    a_r2_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);
    a_r2_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(res));
    a_r9_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SADCLR) |=> (res == '0 && sad_acc == '0));

endmodule

// File: tb/tb_vqa_top.sv
`timescale 1ns/1ps
module tb_vqa_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] src_lo = '0;
    logic [31:0] src_hi = '0;
    logic [1:0]  align_off = '0;
    logic [31:0] res;
    logic        res_valid;
    logic [63:0] sad_acc;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int m_acc [4];

    always #2 clk = ~clk;

    vqa_top dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_lo(src_lo), .src_hi(src_hi), .align_off(align_off),
        .res(res), .res_valid(res_valid), .sad_acc(sad_acc)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R10";
            3'd6: return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] lo,
                                          input logic [31:0] hi, input logic [1:0] off);
        logic [31:0] r = '0;
        logic [63:0] pr;
        case (op)
            3'd0: for (int l = 0; l < 4; l++) begin
                      int s = int'(lo[8*l +: 8]) + int'(hi[8*l +: 8]);
                      r[8*l +: 8] = 8'((s > 255) ? 255 : s);
                  end
            3'd1: for (int h = 0; h < 2; h++) begin
                      int s = int'(lo[16*h +: 16]) + int'(hi[16*h +: 16]);
                      r[16*h +: 16] = 16'((s > 65535) ? 65535 : s);
                  end
            3'd2: for (int l = 0; l < 4; l++)
                      r[8*l +: 8] = 8'((int'(lo[8*l +: 8]) + int'(hi[8*l +: 8]) + 1) / 2);
            3'd3: for (int l = 0; l < 4; l++)
                      r[8*l +: 8] = 8'((int'(lo[8*l +: 8]) + int'(hi[8*l +: 8])) / 2);
            3'd4: for (int l = 0; l < 4; l++) begin
                      int d = int'(lo[8*l +: 8]) - int'(hi[8*l +: 8]);
                      r[8*l +: 8] = 8'((d < 0) ? -d : d);
                  end
            3'd5: begin
                      pr = {hi, lo} >> (8 * int'(off));
                      r = pr[31:0];
                  end
            3'd6: r = '0;
            default: r = {hi[23:16], hi[7:0], lo[23:16], lo[7:0]};
        endcase
        return r;
    endfunction

    function automatic logic [63:0] model_acc();
        logic [63:0] v;
        for (int l = 0; l < 4; l++) v[16*l +: 16] = 16'(m_acc[l]);
        return v;
    endfunction

    // inputs driven at a falling edge, outputs sampled at the next falling edge
    task automatic run_op(input logic [2:0] op, input logic [31:0] lo,
                          input logic [31:0] hi, input logic [1:0] off);
        logic [31:0] exp;
        exp = model(op, lo, hi, off);
        if (op == 3'd4)
            for (int l = 0; l < 4; l++) begin
                int d = int'(lo[8*l +: 8]) - int'(hi[8*l +: 8]);
                m_acc[l] = m_acc[l] + ((d < 0) ? -d : d);
                if (m_acc[l] > 65535) m_acc[l] = 65535;
            end
        else if (op == 3'd6)
            for (int l = 0; l < 4; l++) m_acc[l] = 0;
        op_valid  = 1'b1;
        op_code   = op;
        src_lo    = lo;
        src_hi    = hi;
        align_off = off;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        check(op_tag(op), {32'd0, res}, {32'd0, exp});
        check("R2 valid", {63'd0, res_valid}, 64'd1);
        check((op == 3'd4 || op == 3'd6) ? op_tag(op) : "R12 totals", sad_acc, model_acc());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < 4; l++) m_acc[l] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 res", {32'd0, res}, 64'd0);
        check("R1 valid", {63'd0, res_valid}, 64'd0);
        check("R1 totals", sad_acc, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 sweep of absolute differences into the totals
        run_op(3'd6, 32'h0, 32'h0, 2'd0);
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
                logic [7:0] va = 8'(i * 17), vb = 8'(j * 17);
                run_op(3'd4, {va, vb, ~va, 8'(va + vb)}, {vb, va, ~vb, va ^ vb}, 2'd0);
            end

        // R3 R4 R5 R6 R11 sweeps; R12 totals must not move
        for (int op = 0; op < 8; op++) begin
            if (op == 4 || op == 5 || op == 6) continue;
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++) begin
                    logic [7:0] va = 8'(i * 17), vb = 8'(j * 17);
                    run_op(3'(op), {va, vb, ~va, 8'(va + vb)}, {vb, va, ~vb, va ^ vb}, 2'd0);
                end
        end

        // R10 window select at every offset
        for (int off = 0; off < 4; off++)
            for (int i = 0; i < 8; i++)
                run_op(3'd5, 32'h03020100 + 32'(i) * 32'h11111111,
                       32'h07060504 ^ (32'(i) << 5), 2'(off));

        // R2 idle cycle: result holds, valid drops, totals unchanged (R12)
        begin
            logic [31:0] held;
            held = res;
            src_lo = 32'hFFFFFFFF;
            op_code = 3'd4;
            @(posedge clk);
            @(negedge clk);
            check("R2 hold", {32'd0, res}, {32'd0, held});
            check("R2 idle valid", {63'd0, res_valid}, 64'd0);
            check("R12 idle totals", sad_acc, model_acc());
        end

        // R8 saturation of the totals
        run_op(3'd6, 32'h0, 32'h0, 2'd0);
        for (int n = 0; n < 262; n++)
            run_op(3'd4, 32'hFFFFFFFF, 32'h00000000, 2'd0);
        check("R8 saturated", sad_acc, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op(3'd4, 32'h01020304, 32'h00000000, 2'd0);
        check("R8 sticky", sad_acc, 64'hFFFF_FFFF_FFFF_FFFF);

        // R9 clear
        run_op(3'd6, 32'h12345678, 32'h9ABCDEF0, 2'd1);
        check("R9 cleared", sad_acc, 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule